// File: doc/BRIEF.md
# Three-Byte Call Vector Sequencer

This block answers a processor's interrupt acknowledge cycles with a complete three-byte subroutine call. A priority resolver outside the block supplies the winning request number. The processor then pulses an active-low acknowledge strobe three times. For each pulse the block places one byte on the eight-bit data bus: first the call opcode, then the low half of the service address, then its high half.

The service address comes from a programmed table base and the request number. Table slots sit 4 or 8 locations apart. The base can be anywhere in the 16-bit address space, but the bits that fall inside the table are ignored, so the table is aligned. The block latches the target address when the first acknowledge pulse begins. After that, changes to the request number or to the base do not affect the call that is already under way. When the third pulse ends, the block emits a one-cycle completion pulse and goes back to waiting for the opcode pulse.

Top module: `callvec_seq`

## Requirements
- R1: After reset, with the strobe high, `data_oe` and `done` are 0 and `data_out` is 00h. The next acknowledge pulse is treated as the opcode pulse.
- R2: During the first acknowledge pulse of a sequence, `data_out` is CDh.
- R3: During the second pulse, `data_out` is bits 7:0 of the target address.
- R4: During the third pulse, `data_out` is bits 15:8 of the target address. The release of that pulse returns the block to the opcode byte.
- R5: With `spacing8`=0, the target is the base with bits 4:0 cleared, plus the request index times 4.
- R6: With `spacing8`=1, the target is the base with bits 5:0 cleared, plus the request index times 8.
- R7: `data_oe` is 1 exactly while `ack_n` is 0. While `data_oe` is 0, `data_out` is 00h.
- R8: The index, base and spacing are latched in the first clock cycle that samples `ack_n` low for the opcode pulse. Later changes have no effect on the rest of that sequence.
- R9: The byte position advances only at the first clock edge that samples `ack_n` high after a low. A pulse held low for several cycles keeps presenting the same byte.
- R10: `done` is high for exactly one cycle: the cycle after the edge that samples the release of the third pulse. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_n | input | 1 | Active-low acknowledge strobe from the processor |
| req_idx | input | 3 | Index of the winning request, 0 to 7 |
| base_addr | input | 16 | Programmed table base address |
| spacing8 | input | 1 | 1 selects 8-location slots, 0 selects 4-location slots |
| data_out | output | 8 | Byte presented on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-cycle pulse when the call sequence completes |

## Verification
`data_oe` and `data_out` follow `ack_n` and the current byte position with no register in between. They are therefore checked in the same cycle in which the strobe is driven, 2 ns after the clock edge that first samples it. The address latch and the byte counter each update at a single clock edge: the edge that samples the strobe's fall and the edge that samples its rise. `done` is due one cycle after the rise edge of the third pulse, so it is sampled right after that edge and again one cycle later to show that it has dropped. A behavioural model in the bench, written with integer division and a modulo-3 counter, predicts all three outputs and is compared on every cycle. Directed sequences add checks on each byte, on long pulses, and on changes made to the inputs in the middle of a sequence.

// File: rtl/callvec_pkg.sv
`timescale 1ns/1ps
package callvec_pkg;
  localparam int ADDR_W    = 16;
  localparam int IDX_W     = 3;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 1 + ADDR_W / BYTE_W;
  localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2
  } phase_t;

  // Aligned table slot: clear the bits the table occupies, then insert the scaled index.
  function automatic logic [ADDR_W-1:0] slot_addr(
    input logic [ADDR_W-1:0] base,
    input logic [IDX_W-1:0]  idx,
    input logic              wide
  );
    int unsigned       sh;
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] offs;
    sh   = wide ? 3 : 2;
    keep = {ADDR_W{1'b1}} << (IDX_W + sh);
    offs = ADDR_W'(idx) << sh;
    return (base & keep) | offs;
  endfunction
endpackage

// File: rtl/callvec_edge.sv
`timescale 1ns/1ps
module callvec_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fall = prev_q & ~strobe_n;
  assign rise = ~prev_q & strobe_n;
endmodule

// File: rtl/callvec_phase.sv
`timescale 1ns/1ps
module callvec_phase
  import callvec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise,
  output phase_t phase,
  output logic   seq_end,
  output logic   done
);
  phase_t phase_q;
  phase_t phase_nx;

  assign seq_end = rise && (phase_q == PH_HI);

  always_comb begin
    case (phase_q)
      PH_OPC:  phase_nx = PH_LO;
      PH_LO:   phase_nx = PH_HI;
      default: phase_nx = PH_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;
      done    <= 1'b0;
    end else begin
      done <= seq_end;
      if (rise) phase_q <= phase_nx;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/callvec_bytes.sv
`timescale 1ns/1ps
module callvec_bytes
  import callvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              strobe_n,
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wide,
  output logic [ADDR_W-1:0] tgt,
  output logic [BYTE_W-1:0] data,
  output logic              oe
);
  logic              capture;
  logic [BYTE_W-1:0] byte_sel;
  logic [BYTE_W-1:0] addr_byte [NUM_BYTES-1];

  assign capture = fall && (phase == PH_OPC);

  always_ff @(posedge clk) begin
    if (!rst_n)       tgt <= '0;
    else if (capture) tgt <= slot_addr(base, idx, wide);
  end

  for (genvar g = 0; g < NUM_BYTES - 1; g++) begin : g_slice
    assign addr_byte[g] = tgt[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (phase)
      PH_LO:   byte_sel = addr_byte[0];
      PH_HI:   byte_sel = addr_byte[1];
      default: byte_sel = CALL_OP;
    endcase
    oe   = ~strobe_n;
    data = oe ? byte_sel : '0;
  end
endmodule

// File: rtl/callvec_seq.sv
`timescale 1ns/1ps
module callvec_seq
  import callvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_n,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              spacing8,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe,
  output logic              done
);
  logic              ack_fall;
  logic              ack_rise;
  logic              seq_end;
  phase_t            phase_w;
  logic [ADDR_W-1:0] tgt_w;

  callvec_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (ack_n),
    .fall     (ack_fall),
    .rise     (ack_rise)
  );

  callvec_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (ack_rise),
    .phase   (phase_w),
    .seq_end (seq_end),
    .done    (done)
  );

  callvec_bytes u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (ack_fall),
    .strobe_n (ack_n),
    .phase    (phase_w),
    .base     (base_addr),
    .idx      (req_idx),
    .wide     (spacing8),
    .tgt      (tgt_w),
    .data     (data_out),
    .oe       (data_oe)
  );
endmodule

// File: rtl/callvec_seq_checker.sv
`timescale 1ns/1ps
module callvec_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_n,
  input logic        ack_rise,
  input logic        seq_end,
  input logic [1:0]  phase,
  input logic [15:0] tgt,
  input logic [7:0]  data_out,
  input logic        data_oe,
  input logic        done
);
  assert_done_after_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && phase == 2'd2) |=> (done && phase == 2'd0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seq_end));

  assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rise |=> $stable(phase));

  assert_target_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |-> $stable(tgt));

  assert_bus_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == 8'h00 && ack_n));
endmodule

bind callvec_seq callvec_seq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_n    (ack_n),
  .ack_rise (ack_rise),
  .seq_end  (seq_end),
  .phase    (phase_w),
  .tgt      (tgt_w),
  .data_out (data_out),
  .data_oe  (data_oe),
  .done     (done)
);

// File: tb/callvec_seq_bench.sv
`timescale 1ns/1ps
module callvec_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_n = 1'b1;
  logic [2:0]  req_idx = '0;
  logic [15:0] base_addr = '0;
  logic        spacing8 = 1'b0;
  logic [7:0]  data_out;
  logic        data_oe;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  callvec_seq u_callvec_seq (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_idx(req_idx),
    .base_addr(base_addr), .spacing8(spacing8),
    .data_out(data_out), .data_oe(data_oe), .done(done)
  );

  function automatic int ref_target(int b, int i, bit w);
    int step;
    int blk;
    step = w ? 8 : 4;
    blk  = step * 8;
    return (b / blk) * blk + i * step;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int m_cnt  = 0;
  bit m_prev = 1'b1;
  bit m_done = 1'b0;
  int m_tgt  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = 1'b1; m_done = 1'b0; m_tgt = 0;
    end else begin
      m_done = (!m_prev && ack_n && m_cnt == 2);
      if (m_prev && !ack_n && m_cnt == 0)
        m_tgt = ref_target(int'(base_addr), int'(req_idx), spacing8);
      if (!m_prev && ack_n) m_cnt = (m_cnt + 1) % 3;
      m_prev = ack_n;
    end
  end

  // Per-cycle comparison 2 ns after each rising edge
  always @(posedge clk) begin
    int exp_data;
    #2;
    if (!ack_n)
      exp_data = (m_cnt == 0) ? 'hCD : (m_cnt == 1) ? (m_tgt % 256) : (m_tgt / 256) % 256;
    else
      exp_data = 0;
    chk(data_oe == !ack_n, "R7 oe", int'(data_oe), int'(!ack_n));
    chk(int'(data_out) == exp_data,
        (m_cnt == 0) ? "R2 model byte" : (m_cnt == 1) ? "R3 model byte" : "R4 model byte",
        int'(data_out), exp_data);
    chk(done == m_done, "R10 model done", int'(done), int'(m_done));
  end

  task automatic run_seq(input int i, input int b, input bit w, input int hold, input bit scramble);
    int tgt;
    int first;
    int last;
    int exp;
    string atag;
    tgt  = ref_target(b, i, w);
    atag = w ? "R6" : "R5";
    @(negedge clk);
    req_idx = 3'(i); base_addr = 16'(b); spacing8 = w;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      ack_n = 1'b0;
      @(posedge clk); #2;
      first = int'(data_out);
      for (int h = 1; h < hold; h++) begin
        @(posedge clk); #2;
      end
      last = int'(data_out);
      exp = (k == 0) ? 'hCD : (k == 1) ? (tgt % 256) : (tgt / 256);
      if (k == 0) chk(first == exp, "R2 opcode", first, exp);
      else if (k == 1) chk(first == exp, {"R3 low byte ", atag}, first, exp);
      else chk(first == exp, {"R4 high byte ", atag}, first, exp);
      if (scramble && k > 0) chk(first == exp, "R8 latched target", first, exp);
      if (hold > 1) chk(last == first, "R9 held byte", last, first);
      @(negedge clk);
      ack_n = 1'b1;
      if (scramble && k == 0) begin
        req_idx = ~3'(i); base_addr = ~16'(b); spacing8 = ~w;
      end
      if (k == 2) begin
        @(posedge clk); #2;
        chk(done == 1'b1, "R10 done high", int'(done), 1);
        chk(data_oe == 1'b0 && data_out == 8'h00, "R7 released", int'(data_out), 0);
        @(posedge clk); #2;
        chk(done == 1'b0, "R10 done single", int'(done), 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(data_oe == 1'b0, "R1 reset oe", int'(data_oe), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(data_out == 8'h00, "R1 reset data", int'(data_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(5, 'h1234, 1'b0, 1, 1'b0);
    run_seq(7, 'hABFF, 1'b1, 4, 1'b0);
    run_seq(2, 'h8000, 1'b0, 2, 1'b1);
    run_seq(0, 'hFFFF, 1'b1, 1, 1'b0);
    run_seq(7, 'hFFE0, 1'b0, 3, 1'b1);
    run_seq(3, 'h0047, 1'b1, 1, 1'b1);
    repeat (4) @(posedge clk);
    #2;
    chk(data_oe == 1'b0 && done == 1'b0, "R7 idle after sequences", int'(data_oe), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule